// File: doc/BRIEF.md
# Multiplexed Convert Pulse Scheduler

This block turns each rising edge of a sample clock into a burst of convert strobes for a multiplexed ADC. Each strobe starts the conversion of one channel, and the channel index goes out with the strobe. The block counts all time in ticks of its own clock. The channel count, the minimum conversion time, a settling pad, the sample period and an optional fixed override spacing all come in as configuration.

Normally the strobes are spaced at the conversion time plus the pad, so the whole group is sampled close together. If that burst would not fit inside one sample period, the block spreads the strobes evenly over the period instead. When the override is enabled, its spacing replaces both of these choices. The configuration is captured when a burst starts. A done pulse marks the end of each burst. A sample edge that arrives while a burst is still running is dropped and recorded in a sticky flag.

Top module: `cvt_burst_sched`

## Requirements
- R1: A rising edge of `smp_clk_i` seen while idle starts a burst. The first strobe, with channel 0, is high in the clock cycle right after the edge that first samples `smp_clk_i` high.
- R2: A burst issues one single-cycle strobe per channel, with `cvt_chan_o` counting up from 0 to N-1. N is `cfg_nch_i`. A value of 0 is treated as 1, and a value above CH_MAX is treated as CH_MAX.
- R3: If N*(conv+pad) <= period, consecutive strobes are exactly conv+pad cycles apart.
- R4: Otherwise consecutive strobes are floor(period/N) cycles apart, and the remainder is left idle after the last strobe. A computed spacing of 0 becomes 1.
- R5: With `cfg_ovr_en_i` high, the spacing is `cfg_ovr_per_i` (0 becomes 1), whatever the other settings are.
- R6: The configuration is captured in the cycle the burst starts. Changing it during the burst does not alter that burst.
- R7: `burst_done_o` is a one-cycle pulse, high in the cycle after the last strobe.
- R8: A rising edge sampled while a burst is active is ignored. It sets `overrun_o`, which stays high until reset.
- R9: During and after reset, `cvt_stb_o`, `burst_done_o` and `overrun_o` are 0 and `cvt_chan_o` is 0.
- R10: Holding `smp_clk_i` high does not start another burst. Only a new rising edge does.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Timebase clock; one tick per cycle |
| rst_n | input | 1 | Asynchronous active-low reset |
| smp_clk_i | input | 1 | Sample clock level; its rising edge starts a burst |
| cfg_nch_i | input | NCH_W | Number of channels in a burst |
| cfg_conv_i | input | CNT_W | Minimum conversion time in ticks |
| cfg_pad_i | input | CNT_W | Settling pad in ticks, applied to every channel |
| cfg_per_i | input | CNT_W | Sample period in ticks |
| cfg_ovr_en_i | input | 1 | Use the override spacing |
| cfg_ovr_per_i | input | CNT_W | Override spacing in ticks |
| cvt_stb_o | output | 1 | Convert strobe, one cycle per channel |
| cvt_chan_o | output | CH_W | Channel addressed by the current strobe |
| burst_done_o | output | 1 | One-cycle pulse after the last strobe |
| overrun_o | output | 1 | Sticky flag: sample edge arrived during a burst |

## Verification
A timer that reloads wrongly shows at the ports as a strobe landing one or more cycles early or late. This appears at the second strobe of a burst, at most one spacing after the burst starts. A wrong fit or spread choice shifts every strobe from the second one on, and so does a spacing captured mid-burst. An off-by-one in the channel counter or in the last-channel flag shows as one strobe too many or too few, and as a done pulse that is out of place by a whole spacing. A lost or spurious overrun state shows as a flag that is low after an overlapping edge, or high without one. Either way it is visible as soon as the burst completes.

// File: rtl/cvt_sched_pkg.sv
package cvt_sched_pkg;
   typedef enum logic [1:0] {
      SP_FIT      = 2'd0,
      SP_SPREAD   = 2'd1,
      SP_OVERRIDE = 2'd2
   } sp_mode_e;
endpackage

// File: rtl/cvt_edge_det.sv
module cvt_edge_det (
   input  logic clk,
   input  logic rst_n,
   input  logic lvl_i,
   output logic rise_o
);
   logic lvl_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) lvl_q <= 1'b0;
      else        lvl_q <= lvl_i;
   end

   assign rise_o = lvl_i & ~lvl_q;
endmodule

// File: rtl/cvt_spacing_calc.sv
module cvt_spacing_calc
   import cvt_sched_pkg::*;
#(
   parameter int CNT_W  = 16,
   parameter int NCH_W  = 5,
   parameter bit OVR_EN = 1'b1
) (
   input  logic [NCH_W-1:0] nch_i,
   input  logic [CNT_W-1:0] conv_i,
   input  logic [CNT_W-1:0] pad_i,
   input  logic [CNT_W-1:0] per_i,
   input  logic             ovr_en_i,
   input  logic [CNT_W-1:0] ovr_per_i,
   output logic [CNT_W:0]   spacing_o
);
   localparam int SP_W = CNT_W + 1;
   localparam int PW   = SP_W + NCH_W;

   logic [SP_W-1:0]  step;
   logic [PW-1:0]    burst_len;
   logic             fits;
   logic [CNT_W-1:0] quo;
   logic             use_ovr;
   sp_mode_e         mode;
   logic [SP_W-1:0]  raw;

   always_comb begin
      step      = SP_W'(conv_i) + SP_W'(pad_i);
      burst_len = PW'(step) * PW'(nch_i);
      fits      = burst_len <= PW'(per_i);
      quo       = per_i / CNT_W'(nch_i);
   end

   generate
      if (OVR_EN) begin : g_ovr
         assign use_ovr = ovr_en_i;
      end else begin : g_no_ovr
         assign use_ovr = 1'b0;
      end
   endgenerate

   always_comb begin
      if (use_ovr)   mode = SP_OVERRIDE;
      else if (fits) mode = SP_FIT;
      else           mode = SP_SPREAD;
      case (mode)
         SP_FIT:      raw = step;
         SP_SPREAD:   raw = SP_W'(quo);
         SP_OVERRIDE: raw = SP_W'(ovr_per_i);
         default:     raw = step;
      endcase
      spacing_o = (raw == '0) ? SP_W'(1) : raw;
   end
endmodule

// File: rtl/cvt_burst_seq.sv
module cvt_burst_seq #(
   parameter int SP_W  = 17,
   parameter int NCH_W = 5,
   parameter int CH_W  = 4
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             start_req_i,
   input  logic [SP_W-1:0]  spacing_i,
   input  logic [NCH_W-1:0] nch_i,
   output logic             stb_o,
   output logic [CH_W-1:0]  chan_o,
   output logic             done_o,
   output logic             overrun_o
);
   logic             busy_q;
   logic             last_q;
   logic             stb_q;
   logic             done_q;
   logic             ovr_q;
   logic [CH_W-1:0]  chan_q;
   logic [SP_W-1:0]  timer_q;
   logic [SP_W-1:0]  sp_q;
   logic [NCH_W-1:0] nch_q;
   logic [NCH_W-1:0] nxt_chan;

   assign nxt_chan = NCH_W'(chan_q) + NCH_W'(1);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         busy_q  <= 1'b0;
         last_q  <= 1'b0;
         stb_q   <= 1'b0;
         done_q  <= 1'b0;
         ovr_q   <= 1'b0;
         chan_q  <= '0;
         timer_q <= '0;
         sp_q    <= SP_W'(1);
         nch_q   <= NCH_W'(1);
      end else begin
         stb_q  <= 1'b0;
         done_q <= 1'b0;
         if (!busy_q) begin
            if (start_req_i) begin
               busy_q  <= 1'b1;
               stb_q   <= 1'b1;
               chan_q  <= '0;
               timer_q <= spacing_i - SP_W'(1);
               sp_q    <= spacing_i;
               nch_q   <= nch_i;
               last_q  <= (nch_i == NCH_W'(1));
            end
         end else begin
            if (start_req_i) ovr_q <= 1'b1;
            if (last_q) begin
               busy_q <= 1'b0;
               done_q <= 1'b1;
               last_q <= 1'b0;
            end else if (timer_q == '0) begin
               stb_q   <= 1'b1;
               chan_q  <= chan_q + CH_W'(1);
               timer_q <= sp_q - SP_W'(1);
               last_q  <= (nxt_chan == nch_q - NCH_W'(1));
            end else begin
               timer_q <= timer_q - SP_W'(1);
            end
         end
      end
   end

   assign stb_o     = stb_q;
   assign chan_o    = chan_q;
   assign done_o    = done_q;
   assign overrun_o = ovr_q;

   p_first_strobe_r1: assert property (@(posedge clk) disable iff (!rst_n)
      (start_req_i && !busy_q) |=> (stb_o && chan_o == '0));

   p_chan_range_r2: assert property (@(posedge clk) disable iff (!rst_n)
      stb_o |-> (NCH_W'(chan_o) < nch_q));

   p_done_after_last_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (stb_o && NCH_W'(chan_o) == nch_q - NCH_W'(1)) |=> done_o);

   p_done_single_r7: assert property (@(posedge clk) disable iff (!rst_n)
      done_o |=> !done_o);

   p_done_not_stb_r7: assert property (@(posedge clk) disable iff (!rst_n)
      !(done_o && stb_o));

   p_overrun_sticky_r8: assert property (@(posedge clk) disable iff (!rst_n)
      overrun_o |=> overrun_o);

   p_overrun_set_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (start_req_i && busy_q) |=> overrun_o);
endmodule

// File: rtl/cvt_burst_sched.sv
module cvt_burst_sched #(
   parameter int CNT_W  = 16,
   parameter int CH_MAX = 16,
   parameter bit OVR_EN = 1'b1,
   localparam int CH_W  = (CH_MAX > 1) ? $clog2(CH_MAX) : 1,
   localparam int NCH_W = $clog2(CH_MAX + 1)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             smp_clk_i,
   input  logic [NCH_W-1:0] cfg_nch_i,
   input  logic [CNT_W-1:0] cfg_conv_i,
   input  logic [CNT_W-1:0] cfg_pad_i,
   input  logic [CNT_W-1:0] cfg_per_i,
   input  logic             cfg_ovr_en_i,
   input  logic [CNT_W-1:0] cfg_ovr_per_i,
   output logic             cvt_stb_o,
   output logic [CH_W-1:0]  cvt_chan_o,
   output logic             burst_done_o,
   output logic             overrun_o
);
   localparam int SP_W = CNT_W + 1;

   generate
      if (CH_MAX < 1) begin : g_bad_chmax
         $error("cvt_burst_sched: CH_MAX must be at least 1");
      end
      if (CNT_W < NCH_W) begin : g_bad_cntw
         $error("cvt_burst_sched: CNT_W must cover the channel count width");
      end
   endgenerate

   logic             rise;
   logic [NCH_W-1:0] nch_eff;
   logic [SP_W-1:0]  spacing;

   always_comb begin
      if (cfg_nch_i == '0)                    nch_eff = NCH_W'(1);
      else if (cfg_nch_i > NCH_W'(CH_MAX))    nch_eff = NCH_W'(CH_MAX);
      else                                    nch_eff = cfg_nch_i;
   end

   cvt_edge_det u_edge (
      .clk    (clk),
      .rst_n  (rst_n),
      .lvl_i  (smp_clk_i),
      .rise_o (rise)
   );

   cvt_spacing_calc #(
      .CNT_W  (CNT_W),
      .NCH_W  (NCH_W),
      .OVR_EN (OVR_EN)
   ) u_calc (
      .nch_i     (nch_eff),
      .conv_i    (cfg_conv_i),
      .pad_i     (cfg_pad_i),
      .per_i     (cfg_per_i),
      .ovr_en_i  (cfg_ovr_en_i),
      .ovr_per_i (cfg_ovr_per_i),
      .spacing_o (spacing)
   );

   cvt_burst_seq #(
      .SP_W  (SP_W),
      .NCH_W (NCH_W),
      .CH_W  (CH_W)
   ) u_seq (
      .clk         (clk),
      .rst_n       (rst_n),
      .start_req_i (rise),
      .spacing_i   (spacing),
      .nch_i       (nch_eff),
      .stb_o       (cvt_stb_o),
      .chan_o      (cvt_chan_o),
      .done_o      (burst_done_o),
      .overrun_o   (overrun_o)
   );

   p_spacing_nonzero_r4: assert property (@(posedge clk) disable iff (!rst_n)
      spacing != '0);

   p_nch_in_range_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (nch_eff != '0) && (nch_eff <= NCH_W'(CH_MAX)));
endmodule

// File: tb/cvt_burst_sched_tb_top.sv
module cvt_burst_sched_tb_top;
   localparam int CLK_PER = 10;
   localparam int CNT_W   = 16;
   localparam int CH_MAX  = 16;
   localparam int CH_W    = 4;
   localparam int NCH_W   = 5;

   logic             clk = 1'b0;
   logic             rst_n = 1'b0;
   logic             smp = 1'b0;
   logic [NCH_W-1:0] nch = '0;
   logic [CNT_W-1:0] conv = '0;
   logic [CNT_W-1:0] pad = '0;
   logic [CNT_W-1:0] per = '0;
   logic             oen = 1'b0;
   logic [CNT_W-1:0] oper = '0;
   logic             stb;
   logic [CH_W-1:0]  chan;
   logic             done;
   logic             ovr;

   int checks = 0;
   int fails  = 0;
   bit finished = 1'b0;

   always #(CLK_PER/2) clk = ~clk;

   cvt_burst_sched #(.CNT_W(CNT_W), .CH_MAX(CH_MAX), .OVR_EN(1'b1)) dut_i (
      .clk           (clk),
      .rst_n         (rst_n),
      .smp_clk_i     (smp),
      .cfg_nch_i     (nch),
      .cfg_conv_i    (conv),
      .cfg_pad_i     (pad),
      .cfg_per_i     (per),
      .cfg_ovr_en_i  (oen),
      .cfg_ovr_per_i (oper),
      .cvt_stb_o     (stb),
      .cvt_chan_o    (chan),
      .burst_done_o  (done),
      .overrun_o     (ovr)
   );

   task automatic check(input bit ok, input string req, input string what,
                        input int act, input int exp);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
      end
   endtask

   function automatic int exp_spacing(input int n, input int c, input int p,
                                      input int pr, input int oe, input int ov);
      int ne, s;
      ne = (n == 0) ? 1 : ((n > CH_MAX) ? CH_MAX : n);
      if (oe != 0)              s = ov;
      else if (ne * (c + p) <= pr) s = c + p;
      else                      s = pr / ne;
      if (s == 0) s = 1;
      return s;
   endfunction

   // Runs one burst and compares each cycle with the expected strobe and done pattern.
   task automatic run_burst(input int n, input int c, input int p, input int pr,
                            input int oe, input int ov, input int inj_j,
                            input bit hold, input int chg_j, input string tag);
      int ne, s, last_j, len, bad_stb, bad_done, first_j, act_v, exp_v;
      bit exp_stb, exp_done;
      ne = (n == 0) ? 1 : ((n > CH_MAX) ? CH_MAX : n);
      s  = exp_spacing(n, c, p, pr, oe, ov);
      last_j = (ne - 1) * s;
      len = last_j + 8;
      bad_stb = 0; bad_done = 0; first_j = -1; act_v = 0; exp_v = 0;
      @(negedge clk);
      nch = NCH_W'(n); conv = CNT_W'(c); pad = CNT_W'(p); per = CNT_W'(pr);
      oen = oe[0]; oper = CNT_W'(ov);
      smp = 1'b1;
      for (int j = 0; j <= len; j++) begin
         @(negedge clk);
         exp_stb  = ((j % s) == 0) && ((j / s) < ne);
         exp_done = (j == last_j + 1);
         if (stb !== exp_stb || (exp_stb && int'(chan) != j / s)) begin
            bad_stb++;
            if (first_j < 0) begin
               first_j = j;
               act_v = stb ? int'(chan) : -1;
               exp_v = exp_stb ? j / s : -1;
            end
         end
         if (done !== exp_done) bad_done++;
         if (!hold && j == 0) smp = 1'b0;
         if (j == inj_j) smp = 1'b1;
         if (j == inj_j + 1) smp = 1'b0;
         if (j == chg_j) begin
            nch = NCH_W'(2); conv = CNT_W'(1); pad = '0; per = CNT_W'(2);
            oen = 1'b1; oper = CNT_W'(1);
         end
      end
      check(bad_stb == 0, tag, $sformatf("strobe/channel pattern (cycle %0d, chan or -1)", first_j),
            act_v, exp_v);
      check(bad_done == 0, "R7", {tag, " done pulse mismatching cycles"}, bad_done, 0);
      smp = 1'b0;
      repeat (3) @(negedge clk);
   endtask

   task automatic t_reset();
      repeat (3) @(negedge clk);
      check(stb == 1'b0, "R9", "strobe in reset", int'(stb), 0);
      check(done == 1'b0, "R9", "done in reset", int'(done), 0);
      check(ovr == 1'b0, "R9", "overrun in reset", int'(ovr), 0);
      check(chan == '0, "R9", "channel in reset", int'(chan), 0);
      rst_n = 1'b1;
      repeat (2) @(negedge clk);
      check(stb == 1'b0 && ovr == 1'b0, "R9", "idle after reset", int'(stb) + int'(ovr), 0);
   endtask

   task automatic t_fit();
      run_burst(4, 3, 2, 40, 0, 0, -10, 1'b0, -10, "R3 fit spacing 5 (R1 R2)");
      run_burst(3, 4, 2, 18, 0, 0, -10, 1'b0, -10, "R3 exact fit spacing 6");
   endtask

   task automatic t_spread();
      run_burst(4, 5, 5, 30, 0, 0, -10, 1'b0, -10, "R4 spread 30/4 spacing 7");
      run_burst(3, 4, 2, 17, 0, 0, -10, 1'b0, -10, "R4 one tick short spacing 5");
      run_burst(8, 10, 10, 3, 0, 0, -10, 1'b0, -10, "R4 zero quotient spacing 1");
   endtask

   task automatic t_override();
      run_burst(4, 3, 2, 40, 1, 3, -10, 1'b0, -10, "R5 override spacing 3");
      run_burst(2, 3, 2, 40, 1, 0, -10, 1'b0, -10, "R5 override zero spacing 1");
   endtask

   task automatic t_clamp();
      run_burst(0, 2, 2, 100, 0, 0, -10, 1'b0, -10, "R2 zero count one strobe");
      run_burst(20, 0, 1, 1000, 0, 0, -10, 1'b0, -10, "R2 count clamped to 16");
   endtask

   task automatic t_cfg_change();
      run_burst(4, 3, 3, 50, 0, 0, -10, 1'b0, 2, "R6 config change mid-burst");
   endtask

   task automatic t_overrun();
      check(ovr == 1'b0, "R8", "overrun before overlap", int'(ovr), 0);
      run_burst(4, 3, 2, 40, 0, 0, 5, 1'b0, -10, "R8 overlapping edge ignored");
      check(ovr == 1'b1, "R8", "overrun after overlap", int'(ovr), 1);
      run_burst(2, 1, 1, 40, 0, 0, -10, 1'b0, -10, "R8 clean burst after overrun");
      check(ovr == 1'b1, "R8", "overrun stays sticky", int'(ovr), 1);
   endtask

   task automatic t_level_hold();
      run_burst(3, 2, 1, 30, 0, 0, -10, 1'b1, -10, "R10 held level single burst");
   endtask

   initial begin
      t_reset();
      t_fit();
      t_spread();
      t_override();
      t_clamp();
      t_cfg_change();
      t_level_hold();
      t_overrun();
      finished = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   end

   initial begin
      #(CLK_PER * 200000);
      if (!finished) begin
         checks++;
         fails++;
         $display("FAIL watchdog: actual running expected finished");
         $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
         $finish;
      end
   end
endmodule